// File: doc/BRIEF.md
# Mono Framebuffer to Page-Column Transposer

This block converts a rectangle of a one-bit-per-pixel frame store into the byte stream a page-organised monochrome panel expects. The frame store is row-major. Each row takes ceil(PANEL_W/8) bytes, and bit 0 of each byte is the leftmost pixel of its group of eight. The panel instead wants, for each band of eight rows (a page), one byte per column, with the eight vertical pixels of that column packed into it.

A request gives x, y, width and height and is loaded with a one-cycle start pulse. The block widens the rectangle vertically to whole pages and clips it at the panel's bottom edge. It then reads the frame store through a synchronous port with one cycle of read latency. For every group of eight columns it gathers up to eight source bytes, transposes that 8x8 tile, and emits the columns that lie inside the rectangle. Output uses a valid/ready port. Two flags mark the last byte of each page and the last byte of the whole rectangle.

Top module: `mono_page_xposer`

## Requirements
- R1: Out of reset, busy, rd_en and out_valid are all low.
- R2: Source and destination layout. Column j of frame row r is bit (j mod 8) of frame byte r*ceil(PANEL_W/8) + j/8. Read data is taken one cycle after rd_en. Bit k of an output byte is the pixel in row 8*page + k of that column, so bit 0 is the topmost row of the page.
- R3: Order of output. Within a page, columns go out in ascending order from x to x+width-1. Pages go out from top to bottom.
- R4: Vertical extent. The top edge is rounded down to a multiple of 8. The bottom edge y+height is rounded up to a multiple of 8 and then clamped to PANEL_H. The number of pages is the clamped span divided by 8, rounded up.
- R5: In a page that extends past PANEL_H, the bits for rows at or below PANEL_H are zero, and those rows are never read.
- R6: A request yields exactly width times the page count bytes. Afterwards the block returns to idle with out_valid low.
- R7: out_page_last is high on the final column of every page. out_rect_last is high only on the final byte of the request and is always accompanied by out_page_last.
- R8: While out_valid is high and out_ready is low, out_data and both flags hold. No byte is lost or repeated.
- R9: A start pulse while busy is ignored. A request with zero width or zero height is ignored and leaves the block idle. Horizontally, the rectangle must lie inside the panel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_start | input | 1 | Load the request on in_x/in_y/in_w/in_h when idle |
| in_x | input | XW | Left column of the rectangle |
| in_y | input | YW | Top row of the rectangle |
| in_w | input | WW | Width in columns |
| in_h | input | HW | Height in rows |
| busy | output | 1 | A request is in progress |
| rd_en | output | 1 | Frame store read strobe |
| rd_addr | output | AW | Frame store byte address |
| rd_data | input | 8 | Frame store data, one cycle after rd_en |
| out_valid | output | 1 | out_data holds a page-column byte |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Eight vertical pixels, bit 0 topmost |
| out_page_last | output | 1 | Last byte of the current page |
| out_rect_last | output | 1 | Last byte of the request |

## Verification
The bench builds the block with PANEL_W=20 and PANEL_H=21. With three bytes per row, a rectangle can end partway through a source byte and can straddle a group of eight columns. With a height that is not a multiple of eight, the last page has only five real rows, so clamping and masking come into play. The rectangles used have unaligned top edges and bottoms that pass the panel edge, and they are consumed under several ready patterns, including long stalls, so that the rounding, masking and hold behaviour can each be seen on the output stream.

// File: rtl/mono_xpose_pkg.sv
package mono_xpose_pkg;
   typedef enum logic [1:0] {
      XP_IDLE  = 2'd0,
      XP_FETCH = 2'd1,
      XP_DRAIN = 2'd2,
      XP_EMIT  = 2'd3
   } xp_state_t;

   localparam int TILE = 8;
endpackage

// File: rtl/mono_xpose_geom.sv
module mono_xpose_geom #(
   parameter int PANEL_W = 128,
   parameter int PANEL_H = 64,
   parameter int XW = 7,
   parameter int WW = 8,
   parameter int YW = 6,
   parameter int HW = 7,
   parameter int RW = 7,
   parameter int PW = 3
) (
   input  logic [XW-1:0] in_x,
   input  logic [YW-1:0] in_y,
   input  logic [WW-1:0] in_w,
   input  logic [HW-1:0] in_h,
   output logic [XW-1:0] first_col,
   output logic [XW-1:0] last_col,
   output logic [RW-1:0] top_row,
   output logic [PW-1:0] pages_m1,
   output logic          nonzero
);
   localparam int SW = RW + 2;

   logic [SW-1:0] y_ext, h_ext, bot_up, bot_rnd, bot_clip, top_ext, span, npg;
   logic [XW:0]   last_ext;

   always_comb begin
      y_ext    = SW'(in_y);
      h_ext    = SW'(in_h);
      bot_up   = y_ext + h_ext + SW'(7);
      bot_rnd  = {bot_up[SW-1:3], 3'b000};
      bot_clip = (bot_rnd > SW'(PANEL_H)) ? SW'(PANEL_H) : bot_rnd;
      top_ext  = {y_ext[SW-1:3], 3'b000};
      span     = bot_clip - top_ext;
      npg      = (span >> 3) + ((span[2:0] != 3'b000) ? SW'(1) : SW'(0));
      pages_m1 = PW'(npg - SW'(1));
      top_row  = RW'(top_ext);
      nonzero  = (in_w != '0) && (in_h != '0);
      first_col = in_x;
      last_ext  = {1'b0, in_x} + (XW+1)'(in_w) - (XW+1)'(1);
      last_col  = last_ext[XW-1:0];
   end
endmodule

// File: rtl/mono_xpose_fetch.sv
module mono_xpose_fetch #(
   parameter int PANEL_H = 64,
   parameter int BPR = 16,
   parameter int AW = 10,
   parameter int RW = 7,
   parameter int GW = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic [2:0]       slot,
   input  logic [RW-1:0]    row,
   input  logic [GW-1:0]    grp,
   output logic             rd_en,
   output logic [AW-1:0]    rd_addr,
   input  logic [7:0]       rd_data,
   output logic [7:0][7:0]  tile
);
   localparam int DEPTH = BPR * PANEL_H;

   logic       row_ok;
   logic       cap_vld, cap_ok;
   logic [2:0] cap_slot;

   always_comb begin
      row_ok  = row < RW'(PANEL_H);
      rd_en   = issue && row_ok;
      rd_addr = AW'(int'(row) * BPR + int'(grp));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_vld  <= 1'b0;
         cap_ok   <= 1'b0;
         cap_slot <= 3'd0;
         tile     <= '0;
      end else begin
         cap_vld  <= issue;
         cap_ok   <= row_ok;
         cap_slot <= slot;
         if (cap_vld) begin
            tile[cap_slot] <= cap_ok ? rd_data : 8'h00;
         end
      end
   end

   assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> ({1'b0, rd_addr} < (AW+1)'(DEPTH)));

   assert_no_read_past_panel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (cap_ok && cap_vld));
endmodule

// File: rtl/mono_xpose_xbar.sv
module mono_xpose_xbar (
   input  logic [7:0][7:0] tile,
   input  logic [2:0]      sel,
   output logic [7:0]      col_byte
);
   for (genvar k = 0; k < 8; k++) begin : g_bit
      assign col_byte[k] = tile[k][sel];
   end
endmodule

// File: rtl/mono_page_xposer.sv
module mono_page_xposer #(
   parameter int PANEL_W = 128,
   parameter int PANEL_H = 64,
   localparam int XW  = $clog2(PANEL_W),
   localparam int WW  = $clog2(PANEL_W + 1),
   localparam int YW  = $clog2(PANEL_H),
   localparam int HW  = $clog2(PANEL_H + 1),
   localparam int BPR = (PANEL_W + 7) / 8,
   localparam int AW  = $clog2(BPR * PANEL_H)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_start,
   input  logic [XW-1:0] in_x,
   input  logic [YW-1:0] in_y,
   input  logic [WW-1:0] in_w,
   input  logic [HW-1:0] in_h,
   output logic          busy,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   input  logic [7:0]    rd_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [7:0]    out_data,
   output logic          out_page_last,
   output logic          out_rect_last
);
   import mono_xpose_pkg::*;

   localparam int NPG = (PANEL_H + 7) / 8;
   localparam int PW  = (NPG > 1) ? $clog2(NPG) : 1;
   localparam int RW  = $clog2(PANEL_H + 8);
   localparam int GW  = (BPR > 1) ? $clog2(BPR) : 1;

   if (PANEL_W < 8 || PANEL_H < 8) begin : g_bad_size
      $error("panel dimensions must be at least one tile");
   end

   xp_state_t       st;
   logic [2:0]      slot;
   logic [XW-1:0]   col, first_c, last_c;
   logic [RW-1:0]   page_row, fetch_row;
   logic [PW-1:0]   pg, pg_m1;
   logic [GW-1:0]   grp;
   logic [7:0][7:0] tile;
   logic            at_end, pg_last, fire;

   logic [XW-1:0] g_first, g_last;
   logic [RW-1:0] g_top;
   logic [PW-1:0] g_pm1;
   logic          g_ok;

   mono_xpose_geom #(
      .PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .XW(XW), .WW(WW),
      .YW(YW), .HW(HW), .RW(RW), .PW(PW)
   ) u_geom (
      .in_x(in_x), .in_y(in_y), .in_w(in_w), .in_h(in_h),
      .first_col(g_first), .last_col(g_last), .top_row(g_top),
      .pages_m1(g_pm1), .nonzero(g_ok)
   );

   always_comb begin
      fetch_row = page_row + RW'(slot);
      grp       = GW'(col >> 3);
   end

   mono_xpose_fetch #(
      .PANEL_H(PANEL_H), .BPR(BPR), .AW(AW), .RW(RW), .GW(GW)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .issue(st == XP_FETCH), .slot(slot),
      .row(fetch_row), .grp(grp), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .tile(tile)
   );

   mono_xpose_xbar u_xbar (
      .tile(tile), .sel(col[2:0]), .col_byte(out_data)
   );

   always_comb begin
      busy          = (st != XP_IDLE);
      out_valid     = (st == XP_EMIT);
      at_end        = (col == last_c);
      pg_last       = (pg == pg_m1);
      fire          = out_valid && out_ready;
      out_page_last = out_valid && at_end;
      out_rect_last = out_page_last && pg_last;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= XP_IDLE;
         slot     <= 3'd0;
         col      <= '0;
         first_c  <= '0;
         last_c   <= '0;
         page_row <= '0;
         pg       <= '0;
         pg_m1    <= '0;
      end else begin
         case (st)
            XP_IDLE: begin
               if (in_start && g_ok) begin
                  first_c  <= g_first;
                  last_c   <= g_last;
                  col      <= g_first;
                  page_row <= g_top;
                  pg       <= '0;
                  pg_m1    <= g_pm1;
                  slot     <= 3'd0;
                  st       <= XP_FETCH;
               end
            end
            XP_FETCH: begin
               slot <= slot + 3'd1;
               if (slot == 3'd7) st <= XP_DRAIN;
            end
            XP_DRAIN: st <= XP_EMIT;
            XP_EMIT: begin
               if (fire) begin
                  if (at_end) begin
                     if (pg_last) begin
                        st <= XP_IDLE;
                     end else begin
                        pg       <= pg + PW'(1);
                        page_row <= page_row + RW'(8);
                        col      <= first_c;
                        slot     <= 3'd0;
                        st       <= XP_FETCH;
                     end
                  end else begin
                     col <= col + XW'(1);
                     if (col[2:0] == 3'd7) begin
                        slot <= 3'd0;
                        st   <= XP_FETCH;
                     end
                  end
               end
            end
            default: st <= XP_IDLE;
         endcase
      end
   end

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
         && $stable(out_page_last) && $stable(out_rect_last)));

   assert_flag_nest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_rect_last |-> (out_page_last && out_valid));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!out_valid && !rd_en));

   assert_finish_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_rect_last) |=> !busy);

   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && in_start && !(out_valid && out_ready && out_rect_last)) |=> busy);
endmodule

// File: tb/mono_page_xposer_bench.sv
module mono_page_xposer_bench;
   localparam int PW_  = 20;
   localparam int PH_  = 21;
   localparam int XW   = $clog2(PW_);
   localparam int WW   = $clog2(PW_ + 1);
   localparam int YW   = $clog2(PH_);
   localparam int HW   = $clog2(PH_ + 1);
   localparam int BPR  = (PW_ + 7) / 8;
   localparam int DEP  = BPR * PH_;
   localparam int AW   = $clog2(DEP);

   // x, y, w, h, expected bytes, ready mode
   localparam int NV = 6;
   localparam int VEC [NV][6] = '{
      '{0,  0, 20, 21, 60, 0},
      '{3,  5,  7,  2,  7, 1},
      '{9,  9, 11, 10, 22, 2},
      '{15, 17, 1,  1,  1, 3},
      '{0,  8,  8,  8,  8, 1},
      '{7,  0,  2,  9,  4, 2}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_start = 1'b0;
   logic [XW-1:0] in_x = '0;
   logic [YW-1:0] in_y = '0;
   logic [WW-1:0] in_w = '0;
   logic [HW-1:0] in_h = '0;
   logic          busy, rd_en, out_valid, out_page_last, out_rect_last;
   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_data = 8'h00;
   logic [7:0]    out_data;
   logic          out_ready = 1'b0;
   logic [7:0]    img [DEP];

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   mono_page_xposer #(.PANEL_W(PW_), .PANEL_H(PH_)) u_mono_page_xposer (
      .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_x(in_x), .in_y(in_y),
      .in_w(in_w), .in_h(in_h), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_page_last(out_page_last),
      .out_rect_last(out_rect_last)
   );

   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= img[int'(rd_addr)];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input int r0, input int c);
      logic [7:0] b = 8'h00;
      for (int k = 0; k < 8; k++) begin
         if (r0 + k < PH_) b[k] = img[(r0 + k) * BPR + c / 8][c % 8];
      end
      return b;
   endfunction

   task automatic run_rect(input int x, input int y, input int w, input int h,
                           input int nb, input int mode, input int hold,
                           input bit poke);
      int y0, yend, np, p, c, got, guard, hold_left, pages_seen;
      bit done, have_held, rdy;
      logic [7:0] held, e;
      string dreq;
      y0 = (y / 8) * 8;
      yend = ((y + h + 7) / 8) * 8;
      if (yend > PH_) yend = PH_;
      np = (yend - y0 + 7) / 8;
      p = 0; c = x; got = 0; guard = 0; pages_seen = 0;
      done = 0; have_held = 0; hold_left = hold; held = 8'h00;
      @(negedge clk);
      in_x = XW'(x); in_y = YW'(y); in_w = WW'(w); in_h = HW'(h);
      in_start = 1'b1;
      @(negedge clk);
      in_start = 1'b0;
      while (!done && guard < 3000) begin
         guard++;
         if (poke && guard == 4) begin
            in_x = '0; in_y = '0; in_w = WW'(1); in_h = HW'(1); in_start = 1'b1;
         end
         if (poke && guard == 5) in_start = 1'b0;
         rdy = (mode == 0) ? 1'b1 : ((guard % (mode + 1)) != 0);
         if (hold_left > 0 && out_valid) begin
            if (have_held) chk(out_data == held, "R8", "stalled data", out_data, held);
            else begin held = out_data; have_held = 1; end
            hold_left--;
            rdy = 1'b0;
         end
         out_ready = rdy;
         if (out_valid && rdy) begin
            if (p >= np) begin
               chk(0, "R6", "extra byte", got + 1, nb);
               done = 1;
            end else begin
               e = exp_byte(y0 + 8 * p, c);
               dreq = (y0 + 8 * p + 8 > PH_) ? "R5" : ((c == x) ? "R2" : "R3");
               chk(out_data == e, dreq, "data", out_data, e);
               chk(out_page_last == (c == x + w - 1), "R7", "page_last",
                   out_page_last, (c == x + w - 1));
               chk(out_rect_last == ((c == x + w - 1) && p == np - 1), "R7",
                   "rect_last", out_rect_last, ((c == x + w - 1) && p == np - 1));
               got++;
               if (out_page_last) pages_seen++;
               if (out_rect_last) done = 1;
               if (c == x + w - 1) begin p++; c = x; end
               else c++;
            end
         end
         @(negedge clk);
      end
      out_ready = 1'b0;
      chk(done, "R6", "request completed", done, 1);
      chk(got == nb, "R6", "byte count", got, nb);
      chk(pages_seen == np, "R4", "page count", pages_seen, np);
      if (poke) chk(got == nb, "R9", "start while busy ignored", got, nb);
      for (int i = 0; i < 4; i++) begin
         chk(!out_valid && !busy, "R6", "idle after request", out_valid, 0);
         @(negedge clk);
      end
   endtask

   task automatic zero_req(input int w, input int h);
      @(negedge clk);
      in_x = XW'(2); in_y = YW'(3); in_w = WW'(w); in_h = HW'(h);
      in_start = 1'b1;
      @(negedge clk);
      in_start = 1'b0;
      for (int i = 0; i < 12; i++) begin
         chk(!busy && !out_valid && !rd_en, "R9", "zero-size ignored", busy, 0);
         @(negedge clk);
      end
   endtask

   initial begin
      for (int i = 0; i < DEP; i++) img[i] = 8'((i * 73 + 29) ^ (i >> 1));
      repeat (3) @(negedge clk);
      chk(!busy && !out_valid && !rd_en, "R1", "reset outputs", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !out_valid && !rd_en, "R1", "after release", out_valid, 0);
      for (int v = 0; v < NV; v++) begin
         run_rect(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4],
                  VEC[v][5], 0, 1'b0);
      end
      run_rect(9, 9, 11, 10, 22, 0, 7, 1'b0);
      run_rect(0, 0, 20, 21, 60, 1, 0, 1'b1);
      zero_req(0, 5);
      zero_req(4, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule